// File: doc/BRIEF.md
# Memory strobe pulse timing generator

This block drives the active-low strobes of an external static-memory bus with four chip selects. Each chip select owns one pulse register, written and read over a simple register port. The register holds four 7-bit width codes: one for the write strobe, one for the write-side chip select, one for the read strobe and one for the read-side chip select. A code stands for `256 * code[6] + code[5:0]` clock cycles. A code that decodes to zero is stretched to one cycle, so no strobe is ever skipped.

An access request names a chip select and one of four kinds: normal read, write, first read of a page burst, or a later read in the same page. Once the request is accepted, every strobe of the access goes low in the next cycle. Each strobe then rises on its own when its width has elapsed. A single-cycle done pulse marks the end of the access. The block accepts no new request while an access is in progress. A write-protect input freezes the register contents.

Top module: `strobe_pulse_gen`

## Requirements
- R1: After reset, every pulse register reads 0x01010101, `rdN`, `weN` and all of `csN` are high, `reqReady` is 1 and `done` is 0.
- R2: The register for chip select n (n = 0..3) sits at address 0x04 + 16*n. Its fields are: write-strobe code in bits 6:0, write chip-select code in bits 14:8, read-strobe code in bits 22:16, read chip-select code in bits 30:24. Bits 7, 15, 23 and 31 read as 0. Any other address reads 0.
- R3: While `wpEn` is 1, register writes leave the stored value unchanged, and reads still return it.
- R4: A code decodes to 256*code[6] + code[5:0] cycles. A decoded value of 0 is taken as 1.
- R5: A request is accepted at a rising clock edge where `reqValid` and `reqReady` are both 1. All strobes of that access are low in the cycle after that edge.
- R6: Normal read (`reqKind` = 2'b00): `rdN` is low for the read-strobe width, `csN[reqCs]` is low for the read chip-select width, and `weN` stays high.
- R7: Write (`reqKind` = 2'b01): `weN` is low for the write-strobe width, `csN[reqCs]` is low for the write chip-select width, and `rdN` stays high.
- R8: First page read (`reqKind` = 2'b10): `rdN` and `csN[reqCs]` are both low for the read chip-select width. Later page read (`reqKind` = 2'b11): both are low for the read-strobe width.
- R9: `done` is high for exactly one cycle: the first cycle in which all strobes of the access are high again. `reqReady` is 0 from the cycle after acceptance until that cycle. A request presented while `reqReady` is 0 is ignored.
- R10: Only the requested chip select is driven low. At most one `csN` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wpEn | input | 1 | Write-protect enable for the pulse registers |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| reqValid | input | 1 | Access request |
| reqKind | input | 2 | 00 read, 01 write, 10 first page read, 11 later page read |
| reqCs | input | 2 | Chip select of the request |
| reqReady | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle end-of-access pulse |
| rdN | output | 1 | Read strobe, active low |
| weN | output | 1 | Write strobe, active low |
| csN | output | 4 | Chip selects, active low |

## Verification
On every cycle, the assertions check the following: at most one chip select is low, the read and write strobes are never low together, strobes fall right after a load, `done` lasts a single cycle and never overlaps a live strobe, no load happens while busy, and protected writes change no stored code. Exact pulse widths can only be shown by the bench's sweep scenarios. The same holds for the zero-to-one stretch, the page-first versus page-later width choice and the placement of `done` relative to the longer strobe. The sweep writes varied codes into each chip select, including 0, 1, 63, 64 and 127, runs all four access kinds on each, and counts the low cycles against widths decoded in the bench.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int SPG_NUM_CS    = 4;
  localparam int SPG_CS_W      = $clog2(SPG_NUM_CS);
  localparam int SPG_CODE_W    = 7;
  localparam int SPG_HI_WEIGHT = 256;
  localparam int SPG_CNT_W     = $clog2(SPG_HI_WEIGHT + 2 ** (SPG_CODE_W - 1));

  typedef enum logic [1:0] {
    ACC_READ       = 2'b00,
    ACC_WRITE      = 2'b01,
    ACC_PAGE_FIRST = 2'b10,
    ACC_PAGE_NEXT  = 2'b11
  } accKind_t;

  typedef struct packed {
    logic                load;
    accKind_t            kind;
    logic [SPG_CS_W-1:0] cs;
  } ctlStrobes_t;

  // Width code to cycle count; a zero result is stretched to one cycle.
  function automatic logic [SPG_CNT_W-1:0] decodeWidth(input logic [SPG_CODE_W-1:0] code);
    logic [SPG_CNT_W-1:0] w;
    w = (code[SPG_CODE_W-1] ? SPG_CNT_W'(SPG_HI_WEIGHT) : '0)
      + SPG_CNT_W'(code[SPG_CODE_W-2:0]);
    if (w == '0) w = SPG_CNT_W'(1);
    return w;
  endfunction
endpackage

// File: rtl/spg_regfile.sv
module spg_regfile
  import spg_pkg::*;
#(
  parameter int NUM_CS = SPG_NUM_CS,
  parameter int CODE_W = SPG_CODE_W,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wpEn,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic [$clog2(NUM_CS)-1:0]  selCs,
  output logic [CODE_W-1:0]          weCode,
  output logic [CODE_W-1:0]          wrCsCode,
  output logic [CODE_W-1:0]          rdCode,
  output logic [CODE_W-1:0]          rdCsCode
);
  localparam int CS_W     = $clog2(NUM_CS);
  localparam int N_FIELDS = DATA_W / 8;
  localparam int F_WE     = 0;
  localparam int F_WRCS   = 1;
  localparam int F_RD     = 2;
  localparam int F_RDCS   = 3;

  logic [CODE_W-1:0] fieldQ [NUM_CS][N_FIELDS];
  logic [NUM_CS*N_FIELDS*CODE_W-1:0] flatRegs;
  logic              addrHit;
  logic [CS_W-1:0]   addrIdx;
  logic [N_FIELDS-1:0] unusedWrBits;

  assign addrIdx = regAddr[4 +: CS_W];
  assign addrHit = (regAddr[3:0] == 4'h4) &&
                   (32'(regAddr[ADDR_W-1:4]) < NUM_CS);

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          fieldQ[c][f] <= CODE_W'(1);
        else if (regWrEn && !wpEn && addrHit && addrIdx == CS_W'(c))
          fieldQ[c][f] <= regWrData[f*8 +: CODE_W];
      end
      assign flatRegs[(c*N_FIELDS+f)*CODE_W +: CODE_W] = fieldQ[c][f];
    end
  end

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_pad
    assign unusedWrBits[f] = ^regWrData[f*8+CODE_W +: (8-CODE_W)];
  end

  always_comb begin
    regRdData = '0;
    if (addrHit)
      for (int f = 0; f < N_FIELDS; f++)
        regRdData[f*8 +: CODE_W] = fieldQ[addrIdx][f];
  end

  assign weCode   = fieldQ[selCs][F_WE];
  assign wrCsCode = fieldQ[selCs][F_WRCS];
  assign rdCode   = fieldQ[selCs][F_RD];
  assign rdCsCode = fieldQ[selCs][F_RDCS];

  AST_WP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    wpEn |=> $stable(flatRegs)); // R3
endmodule

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
#(
  parameter int NUM_CS = SPG_NUM_CS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [1:0]                reqKind,
  input  logic [$clog2(NUM_CS)-1:0] reqCs,
  input  logic                      finishing,
  output logic                      reqReady,
  output logic                      done,
  output ctlStrobes_t               ctl
);
  logic busyQ;
  logic accept;

  assign accept   = reqValid && !busyQ;
  assign reqReady = !busyQ;

  always_comb begin
    ctl.load = accept;
    ctl.kind = accKind_t'(reqKind);
    ctl.cs   = reqCs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= finishing;
      if (accept)         busyQ <= 1'b1;
      else if (finishing) busyQ <= 1'b0;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !ctl.load); // R9
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady); // R9
endmodule

// File: rtl/spg_timer.sv
module spg_timer
  import spg_pkg::*;
#(
  parameter int NUM_CS = SPG_NUM_CS,
  parameter int CODE_W = SPG_CODE_W,
  parameter int CNT_W  = SPG_CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [CODE_W-1:0] weCode,
  input  logic [CODE_W-1:0] wrCsCode,
  input  logic [CODE_W-1:0] rdCode,
  input  logic [CODE_W-1:0] rdCsCode,
  output logic              finishing,
  output logic              rdN,
  output logic              weN,
  output logic [NUM_CS-1:0] csN
);
  localparam int CS_W = $clog2(NUM_CS);

  // Channel A is the data strobe (read or write), channel B the chip select.
  logic [CNT_W-1:0] aCnt, bCnt, aLoad, bLoad;
  logic             aAct, bAct, aNext, bNext;
  accKind_t         kindQ;
  logic [CS_W-1:0]  csQ;

  always_comb begin
    unique case (ctl.kind)
      ACC_READ:       begin aLoad = decodeWidth(rdCode);   bLoad = decodeWidth(rdCsCode); end
      ACC_WRITE:      begin aLoad = decodeWidth(weCode);   bLoad = decodeWidth(wrCsCode); end
      ACC_PAGE_FIRST: begin aLoad = decodeWidth(rdCsCode); bLoad = decodeWidth(rdCsCode); end
      default:        begin aLoad = decodeWidth(rdCode);   bLoad = decodeWidth(rdCode);   end
    endcase
  end

  assign aNext     = aAct && (aCnt != CNT_W'(1));
  assign bNext     = bAct && (bCnt != CNT_W'(1));
  assign finishing = (aAct || bAct) && !aNext && !bNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aAct  <= 1'b0;
      bAct  <= 1'b0;
      aCnt  <= '0;
      bCnt  <= '0;
      kindQ <= ACC_READ;
      csQ   <= '0;
    end else if (ctl.load) begin
      aAct  <= 1'b1;
      bAct  <= 1'b1;
      aCnt  <= aLoad;
      bCnt  <= bLoad;
      kindQ <= ctl.kind;
      csQ   <= ctl.cs;
    end else begin
      aAct <= aNext;
      bAct <= bNext;
      if (aNext) aCnt <= aCnt - CNT_W'(1);
      if (bNext) bCnt <= bCnt - CNT_W'(1);
    end
  end

  assign rdN = !(aAct && kindQ != ACC_WRITE);
  assign weN = !(aAct && kindQ == ACC_WRITE);

  for (genvar c = 0; c < NUM_CS; c++) begin : g_csn
    assign csN[c] = !(bAct && csQ == CS_W'(c));
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R10
  AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !weN)); // R6
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> ((!rdN || !weN) && !(&csN))); // R5
  AST_FINISH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    finishing |=> (rdN && weN && (&csN))); // R9
endmodule

// File: rtl/strobe_pulse_gen.sv
module strobe_pulse_gen
  import spg_pkg::*;
#(
  parameter int NUM_CS = SPG_NUM_CS,
  parameter int CODE_W = SPG_CODE_W,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpEn,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [CS_W-1:0]   reqCs,
  output logic              reqReady,
  output logic              done,
  output logic              rdN,
  output logic              weN,
  output logic [NUM_CS-1:0] csN
);
  ctlStrobes_t       ctl;
  logic              finishing;
  logic [CODE_W-1:0] weCode, wrCsCode, rdCode, rdCsCode;

  spg_regfile #(.NUM_CS(NUM_CS), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rstN(rstN), .wpEn(wpEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .selCs(ctl.cs), .weCode(weCode), .wrCsCode(wrCsCode),
    .rdCode(rdCode), .rdCsCode(rdCsCode)
  );

  spg_ctrl #(.NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqCs(reqCs), .finishing(finishing), .reqReady(reqReady),
    .done(done), .ctl(ctl)
  );

  spg_timer #(.NUM_CS(NUM_CS), .CODE_W(CODE_W)) u_timer (
    .clk(clk), .rstN(rstN), .ctl(ctl), .weCode(weCode),
    .wrCsCode(wrCsCode), .rdCode(rdCode), .rdCsCode(rdCsCode),
    .finishing(finishing), .rdN(rdN), .weN(weN), .csN(csN)
  );
endmodule

// File: tb/strobe_pulse_gen_tb.sv
module strobe_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wpEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [1:0]  reqCs = '0;
  logic        reqReady, done, rdN, weN;
  logic [3:0]  csN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  strobe_pulse_gen u_dut (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int dec(input logic [6:0] code);
    int w = (code[6] ? 256 : 0) + int'(code[5:0]);
    return (w == 0) ? 1 : w;
  endfunction

  task automatic regWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [7:0] addr, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = addr;
    #1;
    check(regRdData === exp, req, regRdData, exp);
  endtask

  task automatic runAccess(input int cs, input logic [1:0] kind, input int wA, input int wB);
    int aCnt = 0, bCnt = 0, otherStrb = 0, otherCs = 0, doneAt = 0;
    int mx = (wA > wB) ? wA : wB;
    bit isWr = (kind == 2'b01);
    @(negedge clk);
    check(reqReady === 1'b1, "R9 ready before request", reqReady, 1);
    reqValid = 1'b1; reqKind = kind; reqCs = 2'(cs);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 1; k <= 400; k++) begin
      if (k == 1) begin
        check((isWr ? weN : rdN) === 1'b0 && csN[cs] === 1'b0, "R5 strobes low after accept",
              {rdN, weN, csN}, 0);
        check(reqReady === 1'b0, "R9 busy not ready", reqReady, 0);
      end
      if ((isWr ? weN : rdN) === 1'b0) aCnt++;
      if (csN[cs] === 1'b0) bCnt++;
      if ((isWr ? rdN : weN) === 1'b0) otherStrb++;
      for (int c = 0; c < 4; c++) if (c != cs && csN[c] === 1'b0) otherCs++;
      if (done === 1'b1) begin
        doneAt = k;
        check(rdN && weN && (&csN), "R9 strobes high with done", {rdN, weN, csN}, 6'h3f);
        check(reqReady === 1'b1, "R9 ready with done", reqReady, 1);
        break;
      end
      if (k == 1 && mx >= 2) begin
        reqValid = 1'b1; reqKind = isWr ? 2'b00 : 2'b01; reqCs = 2'((cs + 1) % 4);
      end
      if (k == 2) reqValid = 1'b0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    if (kind == 2'b00) begin
      check(aCnt == wA, "R6 read strobe width", aCnt, wA);
      check(bCnt == wB, "R6 read cs width", bCnt, wB);
    end else if (kind == 2'b01) begin
      check(aCnt == wA, "R7 write strobe width", aCnt, wA);
      check(bCnt == wB, "R7 write cs width", bCnt, wB);
    end else begin
      check(aCnt == wA, "R8 page read strobe width", aCnt, wA);
      check(bCnt == wB, "R8 page cs width", bCnt, wB);
    end
    check(otherStrb == 0, "R6 R7 idle strobe stays high", otherStrb, 0);
    check(otherCs == 0, "R10 other chip selects high, busy request ignored", otherCs, 0);
    check(doneAt == mx + 1, "R9 done position", doneAt, mx + 1);
    @(negedge clk);
    check(done === 1'b0, "R9 done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [6:0] codes [8];
    codes = '{7'd0, 7'd1, 7'd2, 7'd63, 7'd64, 7'd65, 7'd127, 7'd5};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdN && weN && (&csN), "R1 strobes high", {rdN, weN, csN}, 6'h3f);
    check(reqReady === 1'b1 && done === 1'b0, "R1 ready/done", {reqReady, done}, 2'b10);
    for (int c = 0; c < 4; c++) regCheck(8'(4 + 16 * c), 32'h0101_0101, "R1 reset value");

    // R2 layout, unused bits, bad address
    regWrite(8'h14, 32'hFFFF_FFFF);
    regCheck(8'h14, 32'h7F7F_7F7F, "R2 unused bits read zero");
    regWrite(8'h24, 32'h1122_3344);
    regCheck(8'h24, 32'h1122_3344, "R2 field readback");
    regCheck(8'h04, 32'h0101_0101, "R2 other register untouched");
    regCheck(8'h08, 32'h0, "R2 unmapped address");
    regCheck(8'h44, 32'h0, "R2 beyond last register");

    // R3 write protect
    wpEn = 1'b1;
    regWrite(8'h24, 32'h0505_0505);
    regCheck(8'h24, 32'h1122_3344, "R3 write ignored under protect");
    wpEn = 1'b0;
    regWrite(8'h24, 32'h0505_0505);
    regCheck(8'h24, 32'h0505_0505, "R3 write accepted unprotected");

    // R4 R6 R7 R8 sweep of codes over chip selects and access kinds
    for (int i = 0; i < 8; i++) begin
      int cs = i % 4;
      logic [6:0] rd   = codes[i];
      logic [6:0] rdCs = codes[(i + 3) % 8];
      logic [6:0] we   = codes[(i + 5) % 8];
      logic [6:0] wrCs = codes[(i + 1) % 8];
      regWrite(8'(4 + 16 * cs), {1'b0, rdCs, 1'b0, rd, 1'b0, wrCs, 1'b0, we});
      runAccess(cs, 2'b00, dec(rd), dec(rdCs));   // R4 R6
      runAccess(cs, 2'b01, dec(we), dec(wrCs));   // R4 R7
      runAccess(cs, 2'b10, dec(rdCs), dec(rdCs)); // R8 first
      runAccess(cs, 2'b11, dec(rd), dec(rd));     // R8 later
    end
    finish();
  end
endmodule